// File: doc/BRIEF.md
# NAND Access Width Adapter

This block connects a 32-bit host register port to a NAND device I/O bus that is 8 or 16 bits wide. The host makes one access of 1, 2 or 4 bytes. The adapter turns it into the matching number of device I/O beats and gathers the read beats back into one host word. Each chip select has a group of small register windows: a command window, an address window and a data window. A write to the command window raises the command-latch strobe. A write to the address window raises the address-latch strobe. Data accesses raise neither strobe.

The device side is a plain request/acknowledge port. A beat is finished when the device acknowledges it. Each beat carries a 16-bit data lane, a width flag, the two latch strobes and the chip-select index. A per-chip-select configuration word tells the adapter whether a NAND device is present and how wide its bus is. The host sees a single done pulse once the whole access has finished. It may start a new access whenever ready is high.

Top module: `nand_width_adapter`

## Requirements
- R1: The device width of a chip select is bit 12 of its configuration word: 0 means an 8-bit bus and 1 means a 16-bit bus. Bit 13 is ignored. `dev_wide` shows the width on every beat.
- R2: Host size code 0 is 1 byte, code 1 is 2 bytes, and codes 2 and 3 are 4 bytes. With an 8-bit device, an access of 1, 2 or 4 bytes makes 1, 2 or 4 beats, least significant byte first. Write bytes go out on `dev_wdata[7:0]` with the upper lane zero. Read beat k fills host bits [8k+7:8k] from `dev_rdata[7:0]`.
- R3: With a 16-bit device, a 2-byte access makes one beat and a 4-byte access makes two beats, lower halfword first. Read beat k fills host bits [16k+15:16k].
- R4: With a 16-bit device, a 1-byte read makes one beat and returns only `dev_rdata[7:0]`, with the upper bits zero. A 1-byte write makes one beat carrying `hst_wdata[15:0]`.
- R5: The windows of chip select i start at byte address 0x60+0x30*i: the command window at +0x1C, the address window at +0x20 and the data window at +0x24. Each window is 4 bytes. Every byte address inside a window acts the same, and `dev_cs` shows i.
- R6: On a command-window write `dev_cle` is 1 and `dev_ale` is 0. On an address-window write `dev_ale` is 1 and `dev_cle` is 0. Data beats raise neither strobe, and the two strobes are never high together.
- R7: Window accesses reach the device only when configuration bits [11:10] of that chip select equal 2'b10 (NAND). Otherwise no beat is issued, a read returns 0 and a write is dropped.
- R8: A read of a command or address window issues no beat and returns 0.
- R9: An access narrower than 4 bytes to any address outside the windows issues no beat and pulses `hst_badwidth` together with `hst_done`. A 4-byte access outside the windows completes with data 0 and no bad-width flag.
- R10: `hst_done` pulses exactly one cycle after the last beat is acknowledged. An access that issues no beat pulses `hst_done` in the cycle after it is accepted. `hst_ready` is low while any beat is outstanding.
- R11: A device request keeps its data, direction and strobes stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hst_req | input | 1 | Host access request, taken while `hst_ready` is high |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_addr | input | ADDR_W (12) | Host byte address |
| hst_size | input | 2 | Access size code (0: 1 B, 1: 2 B, 2/3: 4 B) |
| hst_wdata | input | 32 | Host write data |
| hst_ready | output | 1 | Adapter can take a new access |
| hst_done | output | 1 | Single-cycle completion pulse |
| hst_badwidth | output | 1 | Narrow access outside the windows, with `hst_done` |
| hst_rdata | output | 32 | Gathered read word, valid with `hst_done` |
| cs_cfg | input | NUM_CS*32 (256) | Configuration words, chip select i at bits [32i+31:32i] |
| dev_req | output | 1 | Device beat request |
| dev_we | output | 1 | Beat direction, 1 = write |
| dev_cle | output | 1 | Command-latch strobe |
| dev_ale | output | 1 | Address-latch strobe |
| dev_wide | output | 1 | Beat is on a 16-bit bus |
| dev_cs | output | CS_W (3) | Chip-select index of the beat |
| dev_wdata | output | 16 | Beat write data |
| dev_ack | input | 1 | Device acknowledges the current beat |
| dev_rdata | input | 16 | Beat read data, sampled with `dev_ack` |

## Verification
The assertions assume that `dev_ack` is raised only while `dev_req` is high. They also assume the host raises `hst_req` only when `hst_ready` is high, so the stability and strobe properties describe one access at a time. The bench host task waits for each `hst_done` before it issues the next access. The device model acknowledges only a pending request, after a programmable gap of zero to three cycles. On 8-bit reads it returns data with a non-zero upper lane, so lane masking is exercised.

// File: rtl/nwa_pkg.sv
package nwa_pkg;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_CMD  = 2'd1,
    WIN_ADR  = 2'd2,
    WIN_DAT  = 2'd3
  } nwa_win_e;

  // Host size codes: 0 byte, 1 halfword, 2 and 3 word
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // Index of the final device beat for a size code and device width
  function automatic logic [1:0] nwa_last_beat(input logic [1:0] size, input logic wide);
    logic [1:0] r;
    if (wide) r = size[1] ? 2'd1 : 2'd0;
    else      r = size[1] ? 2'd3 : (size[0] ? 2'd1 : 2'd0);
    return r;
  endfunction

endpackage

// File: rtl/nwa_decode.sv
module nwa_decode
  import nwa_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_CS    = 8,
  parameter int CS_W      = 3,
  parameter int CS_BASE   = 'h60,
  parameter int CS_STRIDE = 'h30,
  parameter int CMD_OFS   = 'h1C,
  parameter int ADR_OFS   = 'h20,
  parameter int DAT_OFS   = 'h24
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output nwa_win_e          win,
  output logic [CS_W-1:0]   cs
);

  localparam int WORD_W = ADDR_W - 2;

  logic     hit_cs [NUM_CS];
  nwa_win_e win_cs [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    localparam logic [ADDR_W-1:0] BASE_I = ADDR_W'(CS_BASE + i * CS_STRIDE);
    localparam logic [WORD_W-1:0] CMD_W  = WORD_W'(CMD_OFS / 4);
    localparam logic [WORD_W-1:0] ADR_W  = WORD_W'(ADR_OFS / 4);
    localparam logic [WORD_W-1:0] DAT_W  = WORD_W'(DAT_OFS / 4);
    logic [ADDR_W-1:0] off;
    logic              above;
    assign off   = addr - BASE_I;
    assign above = (addr >= BASE_I);
    always_comb begin
      win_cs[i] = WIN_NONE;
      if (above) begin
        if (off[ADDR_W-1:2] == CMD_W)      win_cs[i] = WIN_CMD;
        else if (off[ADDR_W-1:2] == ADR_W) win_cs[i] = WIN_ADR;
        else if (off[ADDR_W-1:2] == DAT_W) win_cs[i] = WIN_DAT;
      end
      hit_cs[i] = (win_cs[i] != WIN_NONE);
    end
  end

  always_comb begin
    hit = 1'b0;
    win = WIN_NONE;
    cs  = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (hit_cs[i] && !hit) begin
        hit = 1'b1;
        win = win_cs[i];
        cs  = CS_W'(i);
      end
    end
  end

endmodule

// File: rtl/nwa_cfg_sel.sv
module nwa_cfg_sel #(
  parameter int NUM_CS    = 8,
  parameter int CS_W      = 3,
  parameter int CFG_W     = 32,
  parameter int TYPE_LSB  = 10,
  parameter int WIDTH_BIT = 12
) (
  input  logic [NUM_CS*CFG_W-1:0] cs_cfg,
  input  logic [CS_W-1:0]         cs,
  output logic                    is_nand,
  output logic                    wide
);

  localparam logic [1:0] TYPE_NAND = 2'b10;

  logic [CFG_W-1:0] words [NUM_CS];
  logic [CFG_W-1:0] sel;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_word
    assign words[i] = cs_cfg[i*CFG_W +: CFG_W];
  end

  assign sel     = words[cs];
  assign is_nand = (sel[TYPE_LSB +: 2] == TYPE_NAND);
  assign wide    = sel[WIDTH_BIT];

endmodule

// File: rtl/nwa_seq.sv
module nwa_seq
  import nwa_pkg::*;
#(
  parameter int CS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_req,
  input  logic            acc_we,
  input  logic [1:0]      acc_size,
  input  logic [31:0]     acc_wdata,
  input  logic            acc_hit,
  input  nwa_win_e        acc_win,
  input  logic [CS_W-1:0] acc_cs,
  input  logic            acc_nand,
  input  logic            acc_wide,
  input  logic            acc_badw,
  input  logic            dev_ack,
  output logic            dev_req,
  output logic            dev_we,
  output logic            dev_cle,
  output logic            dev_ale,
  output logic            dev_wide,
  output logic [CS_W-1:0] dev_cs,
  output logic [15:0]     dev_wdata,
  output logic            done,
  output logic            badw,
  output logic            ready,
  output logic [1:0]      beat_idx,
  output logic            rd_cap,
  output logic            rd_clr,
  output logic            rd_narrow
);

  logic            busy_q, busy_d;
  logic [1:0]      idx_q, idx_d;
  logic [1:0]      last_q;
  logic            done_q, done_d;
  logic            bad_q, bad_d;
  logic            we_q, wide_q;
  logic [1:0]      size_q;
  nwa_win_e        win_q;
  logic [CS_W-1:0] cs_q;
  logic [31:0]     wdata_q;
  logic            take, do_io;

  assign take  = acc_req && !busy_q;
  assign do_io = acc_hit && acc_nand && (acc_we || acc_win == WIN_DAT) && !acc_badw;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    bad_d  = 1'b0;
    if (take) begin
      if (do_io) begin
        busy_d = 1'b1;
        idx_d  = 2'd0;
      end else begin
        done_d = 1'b1;
        bad_d  = acc_badw;
      end
    end else if (busy_q && dev_ack) begin
      if (idx_q == last_q) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= 2'd0;
      done_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      done_q <= done_d;
      bad_q  <= bad_d;
    end
  end

  // Access attributes, loaded only when an access is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      wide_q  <= 1'b0;
      size_q  <= SZ_BYTE;
      win_q   <= WIN_NONE;
      cs_q    <= '0;
      wdata_q <= '0;
      last_q  <= 2'd0;
    end else if (take) begin
      we_q    <= acc_we;
      wide_q  <= acc_wide;
      size_q  <= acc_size;
      win_q   <= acc_win;
      cs_q    <= acc_cs;
      wdata_q <= acc_wdata;
      last_q  <= nwa_last_beat(acc_size, acc_wide);
    end
  end

  always_comb begin
    if (wide_q) dev_wdata = wdata_q[{idx_q[0], 4'b0000} +: 16];
    else        dev_wdata = {8'h00, wdata_q[{idx_q, 3'b000} +: 8]};
  end

  assign dev_req   = busy_q;
  assign dev_we    = we_q;
  assign dev_cle   = busy_q && we_q && (win_q == WIN_CMD);
  assign dev_ale   = busy_q && we_q && (win_q == WIN_ADR);
  assign dev_wide  = wide_q;
  assign dev_cs    = cs_q;
  assign done      = done_q;
  assign badw      = bad_q;
  assign ready     = !busy_q;
  assign beat_idx  = idx_q;
  assign rd_cap    = busy_q && dev_ack && !we_q;
  assign rd_clr    = take;
  assign rd_narrow = wide_q && (size_q == SZ_BYTE);

endmodule

// File: rtl/nwa_gather.sv
module nwa_gather (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        cap,
  input  logic        wide,
  input  logic        narrow,
  input  logic [1:0]  idx,
  input  logic [15:0] beat,
  output logic [31:0] word
);

  logic [31:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (clr) begin
      word_d = '0;
    end else if (cap) begin
      if (wide) word_d[{idx[0], 4'b0000} +: 16] = narrow ? {8'h00, beat[7:0]} : beat;
      else      word_d[{idx, 3'b000} +: 8]      = beat[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;

endmodule

// File: rtl/nand_width_adapter.sv
module nand_width_adapter
  import nwa_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_CS    = 8,
  parameter int CFG_W     = 32,
  parameter int CS_BASE   = 'h60,
  parameter int CS_STRIDE = 'h30,
  parameter int CMD_OFS   = 'h1C,
  parameter int ADR_OFS   = 'h20,
  parameter int DAT_OFS   = 'h24,
  parameter int TYPE_LSB  = 10,
  parameter int WIDTH_BIT = 12,
  localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hst_req,
  input  logic                    hst_we,
  input  logic [ADDR_W-1:0]       hst_addr,
  input  logic [1:0]              hst_size,
  input  logic [31:0]             hst_wdata,
  output logic                    hst_ready,
  output logic                    hst_done,
  output logic                    hst_badwidth,
  output logic [31:0]             hst_rdata,
  input  logic [NUM_CS*CFG_W-1:0] cs_cfg,
  output logic                    dev_req,
  output logic                    dev_we,
  output logic                    dev_cle,
  output logic                    dev_ale,
  output logic                    dev_wide,
  output logic [CS_W-1:0]         dev_cs,
  output logic [15:0]             dev_wdata,
  input  logic                    dev_ack,
  input  logic [15:0]             dev_rdata
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic            win_hit;
  nwa_win_e        win_sel;
  logic [CS_W-1:0] win_cs;
  logic            cfg_nand, cfg_wide;
  logic            narrow_bad;
  logic [1:0]      beat_idx;
  logic            rd_cap, rd_clr, rd_narrow;

  nwa_decode #(
    .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .CS_W(CS_W), .CS_BASE(CS_BASE),
    .CS_STRIDE(CS_STRIDE), .CMD_OFS(CMD_OFS), .ADR_OFS(ADR_OFS), .DAT_OFS(DAT_OFS)
  ) u_decode (
    .addr (hst_addr),
    .hit  (win_hit),
    .win  (win_sel),
    .cs   (win_cs)
  );

  nwa_cfg_sel #(
    .NUM_CS(NUM_CS), .CS_W(CS_W), .CFG_W(CFG_W),
    .TYPE_LSB(TYPE_LSB), .WIDTH_BIT(WIDTH_BIT)
  ) u_cfg (
    .cs_cfg  (cs_cfg),
    .cs      (win_cs),
    .is_nand (cfg_nand),
    .wide    (cfg_wide)
  );

  // Narrow host access (size code 0 or 1) outside every window
  assign narrow_bad = !hst_size[1] && !win_hit;

  nwa_seq #(.CS_W(CS_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .acc_req   (hst_req),
    .acc_we    (hst_we),
    .acc_size  (hst_size),
    .acc_wdata (hst_wdata),
    .acc_hit   (win_hit),
    .acc_win   (win_sel),
    .acc_cs    (win_cs),
    .acc_nand  (cfg_nand),
    .acc_wide  (cfg_wide),
    .acc_badw  (narrow_bad),
    .dev_ack   (dev_ack),
    .dev_req   (dev_req),
    .dev_we    (dev_we),
    .dev_cle   (dev_cle),
    .dev_ale   (dev_ale),
    .dev_wide  (dev_wide),
    .dev_cs    (dev_cs),
    .dev_wdata (dev_wdata),
    .done      (hst_done),
    .badw      (hst_badwidth),
    .ready     (hst_ready),
    .beat_idx  (beat_idx),
    .rd_cap    (rd_cap),
    .rd_clr    (rd_clr),
    .rd_narrow (rd_narrow)
  );

  nwa_gather u_gather (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (rd_clr),
    .cap    (rd_cap),
    .wide   (dev_wide),
    .narrow (rd_narrow),
    .idx    (beat_idx),
    .beat   (dev_rdata),
    .word   (hst_rdata)
  );

endmodule

// File: rtl/nwa_chk.sv
module nwa_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hst_ready,
  input logic        hst_done,
  input logic        hst_badwidth,
  input logic        dev_req,
  input logic        dev_we,
  input logic        dev_cle,
  input logic        dev_ale,
  input logic        dev_wide,
  input logic        dev_ack,
  input logic [15:0] dev_wdata
);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_cle && dev_ale));

  // R6
  strobe_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_cle || dev_ale) |-> (dev_req && dev_we));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && !dev_ack) |=> (dev_req && $stable(dev_wdata) && $stable(dev_we)
                               && $stable(dev_cle) && $stable(dev_ale)));

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |-> !hst_ready);

  // R10
  done_after_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_done |-> !dev_req);

  // R9
  bad_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_badwidth |-> hst_done);

  // R2
  narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && dev_we && !dev_wide) |-> (dev_wdata[15:8] == 8'h00));

endmodule

bind nand_width_adapter nwa_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .hst_ready    (hst_ready),
  .hst_done     (hst_done),
  .hst_badwidth (hst_badwidth),
  .dev_req      (dev_req),
  .dev_we       (dev_we),
  .dev_cle      (dev_cle),
  .dev_ale      (dev_ale),
  .dev_wide     (dev_wide),
  .dev_ack      (dev_ack),
  .dev_wdata    (dev_wdata)
);

// File: tb/nand_width_adapter_tb_top.sv
module nand_width_adapter_tb_top;

  logic        clk;
  logic        rst_n;
  logic        hst_req, hst_we;
  logic [11:0] hst_addr;
  logic [1:0]  hst_size;
  logic [31:0] hst_wdata;
  logic        hst_ready, hst_done, hst_badwidth;
  logic [31:0] hst_rdata;
  logic [255:0] cs_cfg;
  logic        dev_req, dev_we, dev_cle, dev_ale, dev_wide, dev_ack;
  logic [2:0]  dev_cs;
  logic [15:0] dev_wdata, dev_rdata;

  nand_width_adapter dut_i (
    .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_we(hst_we),
    .hst_addr(hst_addr), .hst_size(hst_size), .hst_wdata(hst_wdata),
    .hst_ready(hst_ready), .hst_done(hst_done), .hst_badwidth(hst_badwidth),
    .hst_rdata(hst_rdata), .cs_cfg(cs_cfg), .dev_req(dev_req), .dev_we(dev_we),
    .dev_cle(dev_cle), .dev_ale(dev_ale), .dev_wide(dev_wide), .dev_cs(dev_cs),
    .dev_wdata(dev_wdata), .dev_ack(dev_ack), .dev_rdata(dev_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    bit we; bit cle; bit ale; bit wide; int cs; int wdata;
  } beat_t;

  beat_t bq[$];
  int    rdq[$];
  string cur_tag = "R10";
  int    checks = 0;
  int    errors = 0;
  int    ack_gap = 0;
  bit    mon_on = 0;
  bit    zero_flag = 0;
  bit    exp_next = 0;
  int    vseed = 'h1A2B;
  bit    cfg_nand [8];
  bit    cfg_wide [8];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input int cs, input int word);
    cs_cfg[cs*32 +: 32] = word;
    cfg_nand[cs] = (((word >> 10) & 3) == 2);
    cfg_wide[cs] = ((word >> 12) & 1) == 1;
  endtask

  // Device model and per-clock comparison, away from the active edge
  initial begin
    int wcnt;
    bit exp_now;
    beat_t b;
    wcnt = 0;
    dev_ack = 1'b0;
    dev_rdata = 16'h0;
    forever begin
      @(negedge clk);
      dev_ack = 1'b0;
      if (mon_on) begin
        exp_now = exp_next || zero_flag;
        exp_next = 0;
        zero_flag = 0;
        chk(hst_done == exp_now, "R10", hst_done, exp_now);
        if (dev_req) begin
          chk(!hst_ready, "R10", hst_ready, 0);
          if (bq.size() == 0) begin
            chk(0, cur_tag, 1, 0);
            dev_ack = 1'b1;
          end else if (wcnt >= ack_gap) begin
            b = bq.pop_front();
            chk(dev_we == b.we, cur_tag, dev_we, b.we);
            chk(dev_cle == b.cle, "R6", dev_cle, b.cle);
            chk(dev_ale == b.ale, "R6", dev_ale, b.ale);
            chk(dev_wide == b.wide, "R1", dev_wide, b.wide);
            chk(int'(dev_cs) == b.cs, "R5", dev_cs, b.cs);
            if (b.we) chk(int'(dev_wdata) == b.wdata, cur_tag, dev_wdata, b.wdata);
            if (!b.we) dev_rdata = 16'(rdq.pop_front());
            dev_ack = 1'b1;
            wcnt = 0;
            if (bq.size() == 0) exp_next = 1;
          end else begin
            b = bq[0];
            chk(dev_cle == b.cle && dev_ale == b.ale, "R11", {dev_cle, dev_ale}, {b.cle, b.ale});
            if (b.we) chk(int'(dev_wdata) == b.wdata, "R11", dev_wdata, b.wdata);
            wcnt++;
          end
        end
      end
    end
  end

  // One host access with its expected device beats and result
  task automatic access(input string tag, input bit we, input int addr, input int size,
                        input int wdata);
    int nb, cs, rel, win, beats, n, v;
    bit bad, io, wide;
    beat_t b;
    longint exp_rd;
    nb = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    win = 0; cs = 0;
    if (addr >= 'h60 && addr < 'h60 + 8 * 'h30) begin
      cs  = (addr - 'h60) / 'h30;
      rel = (addr - 'h60) % 'h30;
      if (rel >= 'h1C && rel < 'h20) win = 1;
      else if (rel >= 'h20 && rel < 'h24) win = 2;
      else if (rel >= 'h24 && rel < 'h28) win = 3;
    end
    bad  = (nb != 4) && (win == 0);
    io   = (win != 0) && cfg_nand[cs] && (we || win == 3);
    wide = cfg_wide[cs];
    exp_rd = 0;
    cur_tag = tag;
    if (io) begin
      beats = wide ? ((nb == 4) ? 2 : 1) : nb;
      for (int k = 0; k < beats; k++) begin
        b.we = we; b.cle = we && (win == 1); b.ale = we && (win == 2);
        b.wide = wide; b.cs = cs;
        b.wdata = !we ? 0 : wide ? ((wdata >> (16*k)) & 'hFFFF) : ((wdata >> (8*k)) & 'hFF);
        bq.push_back(b);
        if (!we) begin
          v = vseed;
          vseed = (vseed + 'h3B5D) & 'hFFFF;
          rdq.push_back(v);
          if (wide) exp_rd = exp_rd | (longint'((nb == 1) ? (v & 'hFF) : v) << (16*k));
          else      exp_rd = exp_rd | (longint'(v & 'hFF) << (8*k));
        end
      end
    end
    @(posedge clk); #2;
    hst_req = 1'b1; hst_we = we; hst_addr = 12'(addr);
    hst_size = 2'(size); hst_wdata = wdata;
    @(posedge clk); #2;
    hst_req = 1'b0;
    if (!io) zero_flag = 1;
    n = 0;
    while (!hst_done && n < 200) begin
      @(posedge clk); #3;
      n++;
    end
    chk(hst_done, "R10", hst_done, 1);
    chk(hst_badwidth == bad, bad ? "R9" : tag, hst_badwidth, bad);
    if (!we) chk(longint'(hst_rdata) == exp_rd, tag, hst_rdata, exp_rd);
    chk(bq.size() == 0, tag, bq.size(), 0);
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hst_req = 1'b0; hst_we = 1'b0; hst_addr = '0;
    hst_size = '0; hst_wdata = '0; cs_cfg = '0;
    set_cfg(0, 'h0000_0800);  // NAND, 8-bit
    set_cfg(1, 'h0000_1800);  // NAND, 16-bit
    set_cfg(2, 'h0000_1000);  // not NAND
    set_cfg(3, 'h0000_2800);  // NAND, bit 13 set, still 8-bit
    set_cfg(4, 'h0000_3800);  // NAND, 16-bit with bit 13 set
    set_cfg(5, 'h0000_0C00);  // type 3, not NAND
    set_cfg(6, 'h0000_1800);
    set_cfg(7, 'h0000_0800);
    repeat (3) @(posedge clk);
    #3;
    chk(!dev_req && !hst_done && !dev_cle && !dev_ale, "R10", {dev_req, hst_done}, 0);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    chk(hst_ready && !hst_done && !hst_badwidth && !dev_req, "R10",
        {hst_ready, hst_done, hst_badwidth, dev_req}, 4'b1000);
    mon_on = 1;

    // 8-bit device, each window and size
    ack_gap = 0;
    access("R6", 1, 'h07C, 0, 'h0000_00A5);
    access("R6", 1, 'h080, 2, 'h1234_5678);
    access("R2", 1, 'h084, 1, 'h0000_BEEF);
    access("R2", 0, 'h084, 0, 0);
    ack_gap = 1;
    access("R2", 0, 'h084, 1, 0);
    ack_gap = 2;
    access("R2", 0, 'h085, 2, 0);
    access("R2", 1, 'h086, 3, 'hDEAD_C0DE);

    // 16-bit device
    ack_gap = 0;
    access("R3", 1, 'h0B4, 1, 'h0000_CAFE);
    access("R3", 1, 'h0B4, 2, 'h89AB_CDEF);
    access("R3", 0, 'h0B4, 1, 0);
    ack_gap = 3;
    access("R3", 0, 'h0B7, 2, 0);
    ack_gap = 1;
    access("R4", 0, 'h0B4, 0, 0);
    access("R4", 1, 'h0B5, 0, 'h1234_56C3);
    access("R6", 1, 'h0AC, 1, 'h0000_0070);
    access("R6", 1, 'h0B0, 2, 'h0403_0201);

    // Width bit and ignored bit 13
    access("R1", 0, 'h114, 2, 0);
    access("R1", 0, 'h144, 2, 0);

    // Non-NAND chip selects
    access("R7", 0, 'h0E4, 2, 0);
    access("R7", 1, 'h0E4, 2, 'h5555_AAAA);
    access("R7", 1, 'h16C, 0, 'h0000_00FF);
    access("R7", 0, 'h174, 1, 0);

    // Reads of command and address windows
    ack_gap = 0;
    access("R8", 0, 'h07C, 2, 0);
    access("R8", 0, 'h0B0, 1, 0);

    // Outside the windows
    access("R9", 1, 'h050, 0, 'h0000_0011);
    access("R9", 0, 'h050, 2, 0);
    access("R9", 0, 'h078, 1, 0);
    access("R9", 1, 'h07B, 0, 'h0000_0022);
    access("R9", 1, 'h088, 0, 'h0000_0033);
    access("R9", 0, 'h1E0, 0, 0);
    access("R9", 0, 'h1E4, 3, 0);

    // Last chip select and byte offsets inside a window
    access("R5", 1, 'h1D6, 0, 'h0000_0099);
    access("R5", 1, 'h1CF, 0, 'h0000_0042);
    access("R5", 0, 'h1D4, 1, 0);
    access("R5", 1, 'h07E, 0, 'h0000_0017);
    access("R5", 1, 'h1A0, 2, 'hF00D_BA11);

    // Back-to-back accesses with varying gaps
    for (int i = 0; i < 8; i++) begin
      ack_gap = i % 4;
      access("R10", i[0], 'h084 + 'h30 * (i % 2), i % 3, 'h0101_0101 * (i + 1));
    end

    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule